// File: doc/BRIEF.md
# Execute-Stage Operand Bypass with Write-First Register File

This block supplies the two ALU operands of a five-stage integer pipeline's execute stage. It holds the general-purpose register file. Decode reads two registers from it. The values it reads, together with their register indices, are captured into the decode/execute boundary register at each clock edge.

In execute, each operand is taken from one of three sources. The first is the captured register-file value. The second is the ALU result now in the EX/MEM stage. The third is the value now being written back from MEM/WB. The choice is made by comparing the operand's source index with the destination index and write enable of each later stage.

The register file writes before it reads within a cycle. A value being written back is therefore already visible to the decode read in the same cycle. Taken together, the bypass and the write-first register file cover producer-to-consumer distances of one, two and three instructions without a stall.

Top module: `exec_operand_fwd`

## Requirements
- R1: After reset every register reads as zero, and both execute operands are zero with select code 00.
- R2: Each operand has a select code: 00 means the register-file value, 10 means the EX/MEM result, 01 means the MEM/WB value, and 11 never appears. With no matching producer, the operand equals the register value captured at decode and the select code is 00.
- R3: When EX/MEM has its write enable set and a nonzero destination equal to the operand's source index, the operand equals the EX/MEM result and the select code is 10.
- R4: When only MEM/WB has its write enable set and a nonzero destination equal to the operand's source index, the operand equals the MEM/WB value and the select code is 01.
- R5: When both stages match the same source index, the EX/MEM result is chosen (select code 10).
- R6: A stage whose write enable is low never causes a bypass, even if its destination equals the source index.
- R7: A stage whose destination is register 0 never causes a bypass. An operand whose source is register 0 is always zero.
- R8: A write to register 0 is discarded, and register 0 continues to read as zero.
- R9: A decode read of the register being written back in the same cycle returns the new value.
- R10: A written value stays in the register file and is returned by later reads when no bypass applies.
- R11: The two operands are selected independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_src_a | input | AW | Decode-stage source index, operand A |
| dec_src_b | input | AW | Decode-stage source index, operand B |
| xm_wr_en | input | 1 | EX/MEM register-write enable |
| xm_dst | input | AW | EX/MEM destination index |
| xm_result | input | XLEN | EX/MEM ALU result |
| wb_wr_en | input | 1 | MEM/WB register-write enable (also the register-file write) |
| wb_dst | input | AW | MEM/WB destination index |
| wb_result | input | XLEN | MEM/WB write-back value |
| ex_opnd_a | output | XLEN | Execute operand A |
| ex_opnd_b | output | XLEN | Execute operand B |
| ex_sel_a | output | 2 | Select code for operand A |
| ex_sel_b | output | 2 | Select code for operand B |

## Verification
Several properties are checked by assertions on every cycle. These are the select-code legality, the EX/MEM and MEM/WB bypass outcomes including the priority between them, the no-bypass case when both enables are low, the zero operand for source register 0, and the same-cycle write-first capture. Register-file retention and the discarding of writes to register 0 need a history of writes and reads. Only the bench's sweeps show these, by comparing against a register model kept in the bench. The bench sweeps all pairings of source, destinations and enables over the low registers, covering each distance and priority case.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    typedef enum logic [1:0] {
        SEL_RF = 2'b00,
        SEL_WB = 2'b01,
        SEL_XM = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/gpr_bank.sv
module gpr_bank #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    parameter int NRD   = 2,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_idx,
    input  logic [XLEN-1:0]           wr_data,
    input  logic [NRD-1:0][AW-1:0]    rd_idx,
    output logic [NRD-1:0][XLEN-1:0]  rd_data
);
    logic [NREGS-1:0][XLEN-1:0] mem_d, mem_q;
    logic                       wr_ok;

    assign wr_ok = wr_en && (wr_idx != '0);

    always_comb begin
        mem_d = mem_q;
        if (wr_ok) mem_d[wr_idx] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    // write-first: a write in this cycle is visible to this cycle's read
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (rd_idx[p] == '0)
                rd_data[p] = '0;
            else if (wr_ok && (wr_idx == rd_idx[p]))
                rd_data[p] = wr_data;
            else
                rd_data[p] = mem_q[rd_idx[p]];
        end
    end
endmodule

// File: rtl/operand_bypass.sv
module operand_bypass
    import fwd_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input  logic [AW-1:0]   src,
    input  logic [XLEN-1:0] rf_val,
    input  logic            xm_we,
    input  logic [AW-1:0]   xm_rd,
    input  logic [XLEN-1:0] xm_val,
    input  logic            wb_we,
    input  logic [AW-1:0]   wb_rd,
    input  logic [XLEN-1:0] wb_val,
    output logic [XLEN-1:0] opnd,
    output fwd_sel_e        sel
);
    logic xm_hit, wb_hit;

    assign xm_hit = xm_we && (xm_rd != '0) && (xm_rd == src);
    assign wb_hit = wb_we && (wb_rd != '0) && (wb_rd == src);

    always_comb begin
        if (xm_hit)      sel = SEL_XM;
        else if (wb_hit) sel = SEL_WB;
        else             sel = SEL_RF;
    end

    always_comb begin
        unique case (sel)
            SEL_XM:  opnd = xm_val;
            SEL_WB:  opnd = wb_val;
            default: opnd = rf_val;
        endcase
    end
endmodule

// File: rtl/exec_operand_fwd.sv
module exec_operand_fwd
    import fwd_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREGS = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   dec_src_a,
    input  logic [AW-1:0]   dec_src_b,
    input  logic            xm_wr_en,
    input  logic [AW-1:0]   xm_dst,
    input  logic [XLEN-1:0] xm_result,
    input  logic            wb_wr_en,
    input  logic [AW-1:0]   wb_dst,
    input  logic [XLEN-1:0] wb_result,
    output logic [XLEN-1:0] ex_opnd_a,
    output logic [XLEN-1:0] ex_opnd_b,
    output logic [1:0]      ex_sel_a,
    output logic [1:0]      ex_sel_b
);
    localparam int NOP = 2;

    typedef struct packed {
        logic [NOP-1:0][AW-1:0]   src;
        logic [NOP-1:0][XLEN-1:0] val;
    } idex_t;

    idex_t                    idex_d, idex_q;
    logic [NOP-1:0][AW-1:0]   dec_src;
    logic [NOP-1:0][XLEN-1:0] dec_val;
    logic [NOP-1:0][XLEN-1:0] opnd;
    fwd_sel_e                 sel [NOP];

    assign dec_src[0] = dec_src_a;
    assign dec_src[1] = dec_src_b;

    gpr_bank #(.XLEN(XLEN), .NREGS(NREGS), .NRD(NOP)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wb_wr_en),
        .wr_idx  (wb_dst),
        .wr_data (wb_result),
        .rd_idx  (dec_src),
        .rd_data (dec_val)
    );

    always_comb begin
        idex_d.src = dec_src;
        idex_d.val = dec_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idex_q <= '0;
        else        idex_q <= idex_d;
    end

    for (genvar i = 0; i < NOP; i++) begin : g_op
        operand_bypass #(.XLEN(XLEN), .AW(AW)) u_byp (
            .src    (idex_q.src[i]),
            .rf_val (idex_q.val[i]),
            .xm_we  (xm_wr_en),
            .xm_rd  (xm_dst),
            .xm_val (xm_result),
            .wb_we  (wb_wr_en),
            .wb_rd  (wb_dst),
            .wb_val (wb_result),
            .opnd   (opnd[i]),
            .sel    (sel[i])
        );
    end

    logic [AW-1:0]   ex_src_a, ex_src_b;
    logic [XLEN-1:0] ex_rf_a, ex_rf_b;

    assign ex_src_a  = idex_q.src[0];
    assign ex_src_b  = idex_q.src[1];
    assign ex_rf_a   = idex_q.val[0];
    assign ex_rf_b   = idex_q.val[1];
    assign ex_opnd_a = opnd[0];
    assign ex_opnd_b = opnd[1];
    assign ex_sel_a  = sel[0];
    assign ex_sel_b  = sel[1];
endmodule

// File: rtl/exec_operand_fwd_chk.sv
module exec_operand_fwd_chk #(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   dec_src_a,
    input logic            xm_wr_en,
    input logic [AW-1:0]   xm_dst,
    input logic [XLEN-1:0] xm_result,
    input logic            wb_wr_en,
    input logic [AW-1:0]   wb_dst,
    input logic [XLEN-1:0] wb_result,
    input logic [XLEN-1:0] ex_opnd_a,
    input logic [XLEN-1:0] ex_opnd_b,
    input logic [1:0]      ex_sel_a,
    input logic [1:0]      ex_sel_b,
    input logic [AW-1:0]   ex_src_a,
    input logic [AW-1:0]   ex_src_b,
    input logic [XLEN-1:0] ex_rf_a
);
    assert_sel_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_sel_a != 2'b11) && (ex_sel_b != 2'b11));

    assert_xm_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xm_wr_en && xm_dst != '0 && xm_dst == ex_src_a)
        |-> (ex_sel_a == 2'b10 && ex_opnd_a == xm_result));

    assert_wb_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_wr_en && wb_dst != '0 && wb_dst == ex_src_b
         && !(xm_wr_en && xm_dst != '0 && xm_dst == ex_src_b))
        |-> (ex_sel_b == 2'b01 && ex_opnd_b == wb_result));

    // R5: EX/MEM wins when both stages match
    assert_xm_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xm_wr_en && wb_wr_en && xm_dst == wb_dst && xm_dst != '0 && xm_dst == ex_src_b)
        |-> (ex_sel_b == 2'b10 && ex_opnd_b == xm_result));

    assert_no_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!xm_wr_en && !wb_wr_en) |-> (ex_sel_a == 2'b00 && ex_opnd_a == ex_rf_a));

    assert_zero_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_src_a == '0) |-> (ex_opnd_a == '0 && ex_sel_a == 2'b00));

    assert_write_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wb_wr_en && wb_dst != '0 && wb_dst == dec_src_a))
        |-> (ex_rf_a == $past(wb_result)));
endmodule

bind exec_operand_fwd exec_operand_fwd_chk #(.XLEN(XLEN), .AW(AW)) u_chk (.*);

// File: tb/exec_operand_fwd_test.sv
module exec_operand_fwd_test;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;
    localparam int NREGS = 32;
    localparam int AW = $clog2(NREGS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] dec_src_a = '0, dec_src_b = '0, xm_dst = '0, wb_dst = '0;
    logic xm_wr_en = 1'b0, wb_wr_en = 1'b0;
    logic [XLEN-1:0] xm_result = '0, wb_result = '0;
    logic [XLEN-1:0] ex_opnd_a, ex_opnd_b;
    logic [1:0] ex_sel_a, ex_sel_b;

    int checks = 0;
    int errors = 0;
    logic [XLEN-1:0] shadow [NREGS];

    always #(CLK_PERIOD/2) clk = ~clk;

    exec_operand_fwd #(.XLEN(XLEN), .NREGS(NREGS)) uut (.*);

    task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string tag_for(int s, bit xwe, int xrd, bit wwe, int wrd);
        bit xh = xwe && xrd != 0 && xrd == s;
        bit wh = wwe && wrd != 0 && wrd == s;
        if (xh && wh) return "R5";
        if (xh) return "R3";
        if (wh) return "R4";
        if (s == 0) return "R7";
        if ((xwe && xrd == s) || (wwe && wrd == s)) return "R6";
        return "R2";
    endfunction

    task automatic exp_op(int s, logic [XLEN-1:0] rf, bit xwe, int xrd, bit wwe, int wrd,
                          output logic [XLEN-1:0] v, output logic [1:0] sel);
        if (xwe && xrd != 0 && xrd == s) begin v = xm_result; sel = 2'b10; end
        else if (wwe && wrd != 0 && wrd == s) begin v = wb_result; sel = 2'b01; end
        else begin v = rf; sel = 2'b00; end
    endtask

    task automatic run_case(int a, int b, bit xwe, int xrd, bit wwe, int wrd);
        logic [XLEN-1:0] rfa, rfb, ea, eb;
        logic [1:0] sa, sb;
        @(negedge clk);
        dec_src_a = AW'(a); dec_src_b = AW'(b);
        xm_wr_en = 1'b0; wb_wr_en = 1'b0;
        rfa = shadow[a]; rfb = shadow[b];
        @(negedge clk);
        dec_src_a = '0; dec_src_b = '0;
        xm_wr_en = xwe; xm_dst = AW'(xrd);
        wb_wr_en = wwe; wb_dst = AW'(wrd);
        xm_result = {8'hA5, 8'(a), 8'(xrd), 8'(wrd)};
        wb_result = {8'h5B, 8'(b), 8'(wrd), 8'(xrd)};
        #1;
        exp_op(a, rfa, xwe, xrd, wwe, wrd, ea, sa);
        exp_op(b, rfb, xwe, xrd, wwe, wrd, eb, sb);
        // R11: both operands checked against their own sources
        chk(tag_for(a, xwe, xrd, wwe, wrd), ex_opnd_a, ea);
        chk(tag_for(a, xwe, xrd, wwe, wrd), 32'(ex_sel_a), 32'(sa));
        chk(tag_for(b, xwe, xrd, wwe, wrd), ex_opnd_b, eb);
        chk(tag_for(b, xwe, xrd, wwe, wrd), 32'(ex_sel_b), 32'(sb));
        if (wwe && wrd != 0) shadow[wrd] = wb_result;
    endtask

    initial begin
        for (int i = 0; i < NREGS; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", ex_opnd_a, '0);
        chk("R1", ex_opnd_b, '0);
        chk("R1", 32'(ex_sel_a), 32'b00);
        chk("R1", 32'(ex_sel_b), 32'b00);
        for (int r = 1; r < 8; r++) begin
            @(negedge clk); dec_src_a = AW'(r); dec_src_b = AW'(8 - r);
            @(negedge clk); #1;
            chk("R1", ex_opnd_a, '0);
            chk("R1", ex_opnd_b, '0);
        end

        // R8: write to register 0 is discarded
        @(negedge clk); wb_wr_en = 1'b1; wb_dst = '0; wb_result = 32'hDEAD_BEEF; dec_src_a = '0;
        @(negedge clk); wb_wr_en = 1'b0; #1;
        chk("R8", ex_opnd_a, '0);
        @(negedge clk); dec_src_a = '0;
        @(negedge clk); #1;
        chk("R8", ex_opnd_a, '0);

        // R9: same-cycle write then read returns new value
        for (int r = 1; r < 8; r++) begin
            @(negedge clk);
            dec_src_a = AW'(r); wb_wr_en = 1'b1; wb_dst = AW'(r);
            wb_result = 32'h1234_0000 + 32'(r);
            @(negedge clk);
            wb_wr_en = 1'b0; dec_src_a = '0; #1;
            chk("R9", ex_opnd_a, 32'h1234_0000 + 32'(r));
            chk("R9", 32'(ex_sel_a), 32'b00);
            shadow[r] = 32'h1234_0000 + 32'(r);
        end

        // R10: values persist
        for (int r = 1; r < 8; r++) begin
            @(negedge clk); dec_src_a = AW'(r); dec_src_b = AW'(r);
            @(negedge clk); #1;
            chk("R10", ex_opnd_a, shadow[r]);
            chk("R10", ex_opnd_b, shadow[r]);
        end

        // sweep: sources, destinations and enables over registers 0..7
        for (int a = 0; a < 8; a++)
            for (int xrd = 0; xrd < 8; xrd++)
                for (int wrd = 0; wrd < 8; wrd++)
                    for (int we = 0; we < 4; we++)
                        run_case(a, 7 - a, we[0], xrd, we[1], wrd);

        // R10: final read-back of the model
        for (int r = 0; r < 8; r++) begin
            @(negedge clk); dec_src_a = AW'(r); dec_src_b = AW'(r);
            xm_wr_en = 1'b0; wb_wr_en = 1'b0;
            @(negedge clk); #1;
            chk("R10", ex_opnd_a, shadow[r]);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule